// File: doc/BRIEF.md
# Hardware-Register Read Unit

This unit executes the instruction that lets software running at any privilege level read a small set of hardware registers on a 32-bit RISC core. Each request names one register through a 5-bit selector. The unit decides whether the access is allowed, forms the 32-bit value, and either asserts a write-enable for the destination general register or requests a reserved-instruction exception. The two outcomes are mutually exclusive.

The readable registers are:
- the processor number, taken from the exception-base input;
- the cache-line synchronisation step;
- a free-running cycle counter held inside the unit;
- that counter's resolution;
- two implementation-dependent slots that always read as zero.

One selector is the thread-pointer slot. This full-system build does not support it, so it always faults. Every other selector value faults without any permission check.

The decode path is combinational from `valid_i` to the outputs. The only state is the cycle counter and its prescaler. The counter is also driven out on its own port.

Top module: `hwreg_read_unit`

## Requirements
- R1: For the gated selectors (0, 1, 2, 3, 30, 31), access is granted when at least one of these holds: `user_mode_i` is low, bit `sel_i` of `hw_en_mask_i` is set, or `cu0_i` is set. A granted access with `valid_i` high asserts `wr_en_o`. Otherwise `ri_exc_o` is asserted and `wr_en_o` stays low.
- R2: Selector 0 returns bits [9:0] of `ebase_i`, zero-extended to 32 bits.
- R3: Selector 1 returns the parameter `SYNC_STEP` (default 32).
- R4: Selector 2 returns the cycle counter value held in the register during that cycle, which is the value on `cycle_cnt_o`.
- R5: Selector 3 returns the parameter `CTR_RES` (default 2).
- R6: Selectors 30 and 31 return zero when granted.
- R7: Selector 29 always raises `ri_exc_o`, even in kernel mode with every enable bit and `cu0_i` set.
- R8: Selectors 4 to 28 always raise `ri_exc_o`, whatever the privilege mode and permission inputs.
- R9: `wr_en_o` and `ri_exc_o` are never high together, and both are low when `valid_i` is low. `result_o` is zero whenever `wr_en_o` is low.
- R10: The cycle counter is 0 during reset. It then advances by one after every `CTR_RES` rising clock edges and wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A read request is present this cycle |
| sel_i | input | 5 | Hardware-register selector |
| user_mode_i | input | 1 | Core is running in user mode |
| hw_en_mask_i | input | 32 | Per-selector user access enables |
| cu0_i | input | 1 | Coprocessor-0 usable status bit |
| ebase_i | input | 32 | Exception-base register; low 10 bits hold the processor number |
| result_o | output | 32 | Value to write to the destination register |
| wr_en_o | output | 1 | Write `result_o` to the destination register |
| ri_exc_o | output | 1 | Reserved-instruction exception request |
| cycle_cnt_o | output | 32 | Current cycle counter value |

## Verification
A selector-2 read and a counter increment can fall in the same cycle. The read must return the value the counter holds before that edge, not the value after it. The bench provokes this by issuing a selector-2 read in every cycle of a long sweep, so reads land on both phases of the prescaler. It judges each read against an edge count kept by the bench, divided by the resolution. The same cycle can also combine a permission check with a selector that ignores permissions. The sweep crosses every selector with every mode, enable and mask pattern to settle which of the two wins.

// File: rtl/hwreg_pkg.sv
package hwreg_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W  = 5;

  localparam logic [SEL_W-1:0] SEL_CPUNUM = 5'd0;
  localparam logic [SEL_W-1:0] SEL_STEP   = 5'd1;
  localparam logic [SEL_W-1:0] SEL_CYCLE  = 5'd2;
  localparam logic [SEL_W-1:0] SEL_RES    = 5'd3;
  localparam logic [SEL_W-1:0] SEL_TLS    = 5'd29;
  localparam logic [SEL_W-1:0] SEL_IMP0   = 5'd30;
  localparam logic [SEL_W-1:0] SEL_IMP1   = 5'd31;

  typedef enum logic [1:0] {
    CLS_GATED   = 2'd0,
    CLS_NOSUPP  = 2'd1,
    CLS_INVALID = 2'd2
  } sel_cls_e;

  function automatic sel_cls_e classify(input logic [SEL_W-1:0] sel);
    case (sel)
      SEL_CPUNUM, SEL_STEP, SEL_CYCLE, SEL_RES, SEL_IMP0, SEL_IMP1: classify = CLS_GATED;
      SEL_TLS:                                                     classify = CLS_NOSUPP;
      default:                                                     classify = CLS_INVALID;
    endcase
  endfunction
endpackage

// File: rtl/hwreg_cycle_ctr.sv
module hwreg_cycle_ctr #(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned CTR_RES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  generate
    if (CTR_RES <= 1) begin : g_every_clk
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_q + 1'b1;
      end
    end else begin : g_prescaled
      localparam int unsigned PRE_W = $clog2(CTR_RES);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CTR_RES - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          pre_q <= '0;
          cnt_q <= '0;
        end else if (pre_q == PRE_LAST) begin
          pre_q <= '0;
          cnt_q <= cnt_q + 1'b1;  // wraps modulo 2^CNT_W
        end else begin
          pre_q <= pre_q + 1'b1;
        end
      end
    end
  endgenerate

  assign cnt_o = cnt_q;
endmodule

// File: rtl/hwreg_access_chk.sv
module hwreg_access_chk
  import hwreg_pkg::*;
#(
  parameter int unsigned MASK_W = 32
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              user_mode_i,
  input  logic [MASK_W-1:0] mask_i,
  input  logic              cu0_i,
  output logic              grant_o,
  output logic              fault_o
);
  sel_cls_e cls;
  logic     perm;

  always_comb begin
    cls     = classify(sel_i);
    perm    = !user_mode_i || mask_i[sel_i] || cu0_i;
    grant_o = (cls == CLS_GATED) && perm;
    fault_o = !grant_o;
  end
endmodule

// File: rtl/hwreg_value_mux.sv
module hwreg_value_mux
  import hwreg_pkg::*;
#(
  parameter int unsigned CPUNUM_W  = 10,
  parameter int unsigned SYNC_STEP = 32,
  parameter int unsigned CTR_RES   = 2
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] ebase_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] value_o
);
  localparam logic [DATA_W-1:0] STEP_VAL = DATA_W'(SYNC_STEP);
  localparam logic [DATA_W-1:0] RES_VAL  = DATA_W'(CTR_RES);

  always_comb begin
    case (sel_i)
      SEL_CPUNUM: value_o = {{(DATA_W-CPUNUM_W){1'b0}}, ebase_i[CPUNUM_W-1:0]};
      SEL_STEP:   value_o = STEP_VAL;
      SEL_CYCLE:  value_o = cnt_i;
      SEL_RES:    value_o = RES_VAL;
      default:    value_o = '0;  // implementation slots read zero
    endcase
  end
endmodule

// File: rtl/hwreg_read_unit.sv
module hwreg_read_unit
  import hwreg_pkg::*;
#(
  parameter int unsigned CPUNUM_W  = 10,
  parameter int unsigned SYNC_STEP = 32,
  parameter int unsigned CTR_RES   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        valid_i,
  input  logic [4:0]  sel_i,
  input  logic        user_mode_i,
  input  logic [31:0] hw_en_mask_i,
  input  logic        cu0_i,
  input  logic [31:0] ebase_i,
  output logic [31:0] result_o,
  output logic        wr_en_o,
  output logic        ri_exc_o,
  output logic [31:0] cycle_cnt_o
);
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] value;
  logic              grant;
  logic              fault;

  hwreg_cycle_ctr #(.CNT_W(DATA_W), .CTR_RES(CTR_RES)) i_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (cnt)
  );

  hwreg_access_chk #(.MASK_W(DATA_W)) i_chk (
    .sel_i       (sel_i),
    .user_mode_i (user_mode_i),
    .mask_i      (hw_en_mask_i),
    .cu0_i       (cu0_i),
    .grant_o     (grant),
    .fault_o     (fault)
  );

  hwreg_value_mux #(
    .CPUNUM_W  (CPUNUM_W),
    .SYNC_STEP (SYNC_STEP),
    .CTR_RES   (CTR_RES)
  ) i_mux (
    .sel_i   (sel_i),
    .ebase_i (ebase_i),
    .cnt_i   (cnt),
    .value_o (value)
  );

  assign wr_en_o     = valid_i && grant;
  assign ri_exc_o    = valid_i && fault;
  assign result_o    = wr_en_o ? value : '0;
  assign cycle_cnt_o = cnt;
endmodule

// File: rtl/hwreg_read_unit_checker.sv
module hwreg_read_unit_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [4:0]  sel_i,
  input logic        user_mode_i,
  input logic [31:0] hw_en_mask_i,
  input logic        cu0_i,
  input logic [31:0] result_o,
  input logic        wr_en_o,
  input logic        ri_exc_o,
  input logic [31:0] cycle_cnt_o
);
  assert_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && ri_exc_o));

  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!wr_en_o && !ri_exc_o && result_o == 32'd0));

  assert_nosupp_faults_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i == 5'd29) |-> ri_exc_o);

  assert_invalid_faults_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i >= 5'd4 && sel_i <= 5'd28) |-> ri_exc_o);

  assert_kernel_grant_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !user_mode_i && (sel_i <= 5'd3 || sel_i >= 5'd30)) |-> wr_en_o);

  assert_user_denied_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && user_mode_i && !cu0_i && !hw_en_mask_i[sel_i]) |-> !wr_en_o);

  assert_cycle_read_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && sel_i == 5'd2) |-> result_o == cycle_cnt_o);

  assert_cnt_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_cnt_o == $past(cycle_cnt_o)) || (cycle_cnt_o == $past(cycle_cnt_o) + 32'd1));
endmodule

bind hwreg_read_unit hwreg_read_unit_checker i_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .sel_i        (sel_i),
  .user_mode_i  (user_mode_i),
  .hw_en_mask_i (hw_en_mask_i),
  .cu0_i        (cu0_i),
  .result_o     (result_o),
  .wr_en_o      (wr_en_o),
  .ri_exc_o     (ri_exc_o),
  .cycle_cnt_o  (cycle_cnt_o)
);

// File: tb/test_hwreg_read_unit.sv
`timescale 1ns/1ps
module test_hwreg_read_unit;
  localparam int unsigned STEP = 32;
  localparam int unsigned RES  = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [4:0]  sel = '0;
  logic        user = 1'b0;
  logic [31:0] mask = '0;
  logic        cu0 = 1'b0;
  logic [31:0] ebase = '0;
  logic [31:0] result;
  logic        wr_en;
  logic        ri_exc;
  logic [31:0] cnt;

  int unsigned edges = 0;
  int checks = 0;
  int fails  = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) edges <= edges + 1;

  hwreg_read_unit #(.SYNC_STEP(STEP), .CTR_RES(RES)) i_hwreg_read_unit (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .valid_i      (valid),
    .sel_i        (sel),
    .user_mode_i  (user),
    .hw_en_mask_i (mask),
    .cu0_i        (cu0),
    .ebase_i      (ebase),
    .result_o     (result),
    .wr_en_o      (wr_en),
    .ri_exc_o     (ri_exc),
    .cycle_cnt_o  (cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic string sel_req(input int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      29: return "R7";
      30, 31: return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset count", cnt, 32'd0);
    chk("R9 reset wr_en", {31'd0, wr_en}, 32'd0);
    chk("R9 reset ri_exc", {31'd0, ri_exc}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Every selector, mode, coprocessor bit and mask pattern, one read per cycle
    for (int s = 0; s < 32; s++) begin
      for (int u = 0; u < 2; u++) begin
        for (int c = 0; c < 2; c++) begin
          for (int m = 0; m < 4; m++) begin
            bit gated, perm, grant;
            logic [31:0] expv;
            @(negedge clk);
            valid = 1'b1;
            sel   = 5'(s);
            user  = u[0];
            cu0   = c[0];
            ebase = 32'hA5C3_F000 ^ (32'(s) * 32'h0101_0137);
            case (m)
              0: mask = 32'd0;
              1: mask = 32'hFFFF_FFFF;
              2: mask = 32'd1 << s;
              default: mask = ~(32'd1 << s);
            endcase
            #1;
            gated = (s <= 3) || (s >= 30);
            perm  = (u == 0) || mask[s] || (c == 1);
            grant = gated && perm;
            case (s)
              0: expv = ebase & 32'h3FF;
              1: expv = STEP;
              2: expv = edges / RES;
              3: expv = RES;
              default: expv = 32'd0;
            endcase
            if (!grant) expv = 32'd0;
            chk({"R1 wr_en ", sel_req(s)}, {31'd0, wr_en}, {31'd0, grant});
            chk({"R1 ri_exc ", sel_req(s)}, {31'd0, ri_exc}, {31'd0, !grant});
            chk({"R9 value ", sel_req(s)}, result, expv);
            chk("R10 counter", cnt, edges / RES);
          end
        end
      end
    end

    // With valid low, nothing may come out, even for a fully permitted read
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      valid = 1'b0;
      sel   = 5'(s);
      user  = 1'b0;
      cu0   = 1'b1;
      mask  = 32'hFFFF_FFFF;
      #1;
      chk("R9 idle wr_en", {31'd0, wr_en}, 32'd0);
      chk("R9 idle ri_exc", {31'd0, ri_exc}, 32'd0);
      chk("R9 idle result", result, 32'd0);
    end

    // A long stretch of back-to-back cycle-counter reads in kernel mode
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      valid = 1'b1;
      sel   = 5'd2;
      user  = 1'b0;
      cu0   = 1'b0;
      mask  = 32'd0;
      #1;
      chk("R4 cycle read", result, edges / RES);
      chk("R10 cycle count", cnt, edges / RES);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule